// File: doc/BRIEF.md
# Network Controller Control/Status and Parity Capture

This block is the control/status register set that a host uses to run a network controller on its board. Through a 16-bit register bus the host drives three signals to the controller: reset, leave-loopback (on-air) and a one-cycle attention pulse that tells the controller to look for new work. The block also holds several plain board configuration fields that the host can read back.

Two interrupt sources are merged into a single host interrupt line, and each has its own enable. The first source is a sticky flag that records the controller's interrupt. The second is a memory parity error. On the first parity error the block freezes the failing 20-bit address, the source of the error and the failing byte half. The address is split into a low 16-bit register and a 4-bit high field. These values stay frozen until software writes the acknowledge bit. Parity errors that arrive in the meantime are dropped.

Top module: `ncsr_top`

## Requirements
- R1: After reset every register reads 0. In the status register (address 0), bits 15, 14, 13, 12, 11, 5 and 4, and the field in bits 3:0, are read/write. Bits 10, 7 and 6 always read 0. Writing bit 9 has no effect.
- R2: `ctl_reset_o` equals status bit 15. While this bit is set, the controller interrupt flag and the parity flag are held clear, and parity strobes are ignored. The ignored strobes leave the captured address unchanged.
- R3: `on_air_o` equals status bit 14.
- R4: When a status write changes bit 13 from 0 to 1, `atn_o` goes high for exactly one cycle, in the cycle after the write. A write of 1 to bit 13 while it is already 1 gives no pulse.
- R5: The controller interrupt flag (status bit 8) is sticky. It sets when `ctl_int_i` is high at a clock edge. A status write with bit 8 = 1 clears it. If both happen in the same cycle, the set wins.
- R6: A `perr_i` strobe while the parity flag is clear sets the parity flag (status bit 9) and captures the error. In the parity control register (address 1), bit 7 holds the source, bit 6 holds the byte half, and bits 3:0 hold address bits 19:16. Address 2 holds address bits 15:0.
- R7: While the parity flag is set, further strobes do not change the captured address, source or byte half.
- R8: A write to address 1 with bit 8 = 1 clears the parity flag at that clock edge. Bit 8 always reads 0. The captured values are kept, and the next strobe after the acknowledge is captured.
- R9: `irq_o` = (status bit 8 AND status bit 12) OR (status bit 9 AND status bit 11).
- R10: Address 3 reads 0. Writes to addresses 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| ctl_int_i | input | 1 | Interrupt request from the controller |
| perr_i | input | 1 | Parity error strobe |
| perr_addr_i | input | 20 | Failing address |
| perr_src_i | input | 1 | Error source |
| perr_half_i | input | 1 | Failing byte half |
| ctl_reset_o | output | 1 | Controller reset |
| on_air_o | output | 1 | Leave loopback |
| atn_o | output | 1 | Attention pulse |
| irq_o | output | 1 | Host interrupt |

## Verification
The parity capture is driven with a first error and then with a second error that carries a different address, source and byte half. If the readback still shows the first error, the capture froze; if it shows the second, it was overwritten. A third error after the acknowledge shows that the acknowledge both re-arms the capture and reads back as 0. The host interrupt is driven by each source with its enable off and then on, which separates the two gating terms. The attention bit is written as 0→1 and as 1→1, which shows whether the pulse comes from the edge or from the level. The reset bit is set while both sources fire, which checks that it holds the flags clear.

// File: rtl/ncsr_pkg.sv
package ncsr_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd0;
  localparam logic [REG_AW-1:0] A_PCTL = 2'd1;
  localparam logic [REG_AW-1:0] A_PLOW = 2'd2;

  // status bit positions
  localparam int B_RST   = 15;
  localparam int B_AIR   = 14;
  localparam int B_ATN   = 13;
  localparam int B_IEN   = 12;
  localparam int B_PIEN  = 11;
  localparam int B_PFLG  = 9;
  localparam int B_IFLG  = 8;
  localparam int B_EXP   = 5;
  localparam int B_BIG   = 4;
  // parity control bit positions
  localparam int B_ACK   = 8;
  localparam int B_SRC   = 7;
  localparam int B_HALF  = 6;

  typedef struct packed {
    logic       rst;
    logic       on_air;
    logic       atn;
    logic       ien;
    logic       pien;
    logic       exp_en;
    logic       big_ram;
    logic [3:0] hi_addr;
  } ctl_t;
endpackage

// File: rtl/ncsr_ctrl.sv
module ncsr_ctrl
  import ncsr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        ctl_int_i,
  output ctl_t        ctl_o,
  output logic        atn_pulse_o,
  output logic        int_flag_o
);
  ctl_t ctl_q;
  logic atn_q, iflag_q;
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[10:9], wdata_i[7:6]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      atn_q   <= 1'b0;
      iflag_q <= 1'b0;
    end else begin
      atn_q <= wr_i && wdata_i[B_ATN] && !ctl_q.atn;
      if (wr_i) begin
        ctl_q.rst     <= wdata_i[B_RST];
        ctl_q.on_air  <= wdata_i[B_AIR];
        ctl_q.atn     <= wdata_i[B_ATN];
        ctl_q.ien     <= wdata_i[B_IEN];
        ctl_q.pien    <= wdata_i[B_PIEN];
        ctl_q.exp_en  <= wdata_i[B_EXP];
        ctl_q.big_ram <= wdata_i[B_BIG];
        ctl_q.hi_addr <= wdata_i[3:0];
      end
      if (ctl_q.rst)                       iflag_q <= 1'b0;
      else if (ctl_int_i)                  iflag_q <= 1'b1;  // set wins over clear
      else if (wr_i && wdata_i[B_IFLG])    iflag_q <= 1'b0;
    end
  end

  assign ctl_o       = ctl_q;
  assign atn_pulse_o = atn_q;
  assign int_flag_o  = iflag_q;

  AST_ATN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atn_q |=> !atn_q); // R4
  AST_RST_HOLDS_IFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.rst |=> !iflag_q); // R2
  AST_IFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iflag_q && !ctl_q.rst && !(wr_i && wdata_i[B_IFLG])) |=> iflag_q); // R5
endmodule

// File: rtl/ncsr_perr.sv
module ncsr_perr #(
  parameter int PADDR_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               ack_i,
  input  logic               strobe_i,
  input  logic [PADDR_W-1:0] addr_i,
  input  logic               src_i,
  input  logic               half_i,
  output logic               flag_o,
  output logic [PADDR_W-1:0] addr_o,
  output logic               src_o,
  output logic               half_o
);
  logic               flag_q, src_q, half_q;
  logic [PADDR_W-1:0] addr_q;
  logic               cap;

  assign cap = strobe_i && !flag_q && !hold_i && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (hold_i || ack_i) flag_q <= 1'b0;
      else if (cap)        flag_q <= 1'b1;
      if (cap) begin
        addr_q <= addr_i;
        src_q  <= src_i;
        half_q <= half_i;
      end
    end
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;
  assign src_o  = src_q;
  assign half_o = half_q;

  AST_PERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> $stable(addr_q) && $stable(src_q) && $stable(half_q)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !flag_q); // R8
  AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !flag_q && $stable(addr_q)); // R2
endmodule

// File: rtl/ncsr_top.sv
module ncsr_top
  import ncsr_pkg::*;
#(
  parameter int PADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              ctl_int_i,
  input  logic              perr_i,
  input  logic [PADDR_W-1:0] perr_addr_i,
  input  logic              perr_src_i,
  input  logic              perr_half_i,
  output logic              ctl_reset_o,
  output logic              on_air_o,
  output logic              atn_o,
  output logic              irq_o
);
  localparam int HI_W = PADDR_W - 16;

  ctl_t               ctl;
  logic               iflag, pflag, psrc, phalf;
  logic [PADDR_W-1:0] paddr;
  logic               wr_stat, ack;

  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign ack     = reg_we_i && (reg_addr_i == A_PCTL) && reg_wdata_i[B_ACK];

  ncsr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_stat),
    .wdata_i     (reg_wdata_i),
    .ctl_int_i   (ctl_int_i),
    .ctl_o       (ctl),
    .atn_pulse_o (atn_o),
    .int_flag_o  (iflag)
  );

  ncsr_perr #(.PADDR_W(PADDR_W)) u_perr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (ctl.rst),
    .ack_i    (ack),
    .strobe_i (perr_i),
    .addr_i   (perr_addr_i),
    .src_i    (perr_src_i),
    .half_i   (perr_half_i),
    .flag_o   (pflag),
    .addr_o   (paddr),
    .src_o    (psrc),
    .half_o   (phalf)
  );

  assign ctl_reset_o = ctl.rst;
  assign on_air_o    = ctl.on_air;
  assign irq_o       = (iflag && ctl.ien) || (pflag && ctl.pien);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STAT: begin
        reg_rdata_o[B_RST]  = ctl.rst;
        reg_rdata_o[B_AIR]  = ctl.on_air;
        reg_rdata_o[B_ATN]  = ctl.atn;
        reg_rdata_o[B_IEN]  = ctl.ien;
        reg_rdata_o[B_PIEN] = ctl.pien;
        reg_rdata_o[B_PFLG] = pflag;
        reg_rdata_o[B_IFLG] = iflag;
        reg_rdata_o[B_EXP]  = ctl.exp_en;
        reg_rdata_o[B_BIG]  = ctl.big_ram;
        reg_rdata_o[3:0]    = ctl.hi_addr;
      end
      A_PCTL: begin
        reg_rdata_o[B_SRC]    = psrc;
        reg_rdata_o[B_HALF]   = phalf;
        reg_rdata_o[HI_W-1:0] = paddr[PADDR_W-1:16];
      end
      A_PLOW:  reg_rdata_o = paddr[15:0];
      default: reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (iflag || pflag)); // R9
  AST_RST_OUT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_reset_o && !wr_stat) |=> ctl_reset_o); // R2
endmodule

// File: tb/ncsr_top_tb.sv
`timescale 1ns/1ps
module ncsr_top_tb;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  addr = 0;
  logic        we = 0;
  logic [15:0] wdata = 0, rdata;
  logic        cint = 0, perr = 0, psrc = 0, phalf = 0;
  logic [19:0] paddr = 0;
  logic        rst_o, air_o, atn, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ncsr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ctl_int_i(cint),
    .perr_i(perr), .perr_addr_i(paddr), .perr_src_i(psrc),
    .perr_half_i(phalf), .ctl_reset_o(rst_o), .on_air_o(air_o),
    .atn_o(atn), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse_int();
    @(negedge clk); cint = 1;
    @(negedge clk); cint = 0;
  endtask

  task automatic strobe(logic [19:0] a, logic s, logic h);
    @(negedge clk); perr = 1; paddr = a; psrc = s; phalf = h;
    @(negedge clk); perr = 0;
  endtask

  task automatic t_reset_state();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin rd(i[1:0], d); chk("R1 reset read", d, 16'h0); end
    chk("R2 reset out", {15'b0, rst_o}, 16'h0);
    chk("R9 irq idle", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_status_rw();
    logic [15:0] d;
    wr(0, 16'h5A35); rd(0, d); chk("R1 mask pattern", d, 16'h5835);
    chk("R3 on_air", {15'b0, air_o}, 16'h1);
    wr(0, 16'h0000); rd(0, d); chk("R1 clear", d, 16'h0);
    chk("R3 on_air off", {15'b0, air_o}, 16'h0);
  endtask

  task automatic t_attention();
    logic [15:0] d;
    @(negedge clk); addr = 0; wdata = 16'h2000; we = 1;
    @(negedge clk); we = 0;
    chk("R4 pulse high", {15'b0, atn}, 16'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", {15'b0, atn}, 16'h0);
    @(negedge clk); addr = 0; wdata = 16'h2000; we = 1;
    @(negedge clk); we = 0;
    chk("R4 no pulse 1->1", {15'b0, atn}, 16'h0);
    rd(0, d); chk("R4 bit readback", d, 16'h2000);
    wr(0, 16'h0000);
  endtask

  task automatic t_int_flag();
    logic [15:0] d;
    pulse_int(); rd(0, d); chk("R5 flag set", d, 16'h0100);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R5 sticky", d, 16'h0100);
    chk("R9 irq masked", {15'b0, irq}, 16'h0);
    wr(0, 16'h1000);
    chk("R9 irq via ien", {15'b0, irq}, 16'h1);
    wr(0, 16'h1100); rd(0, d); chk("R5 write1 clears", d, 16'h1000);
    chk("R9 irq drops", {15'b0, irq}, 16'h0);
    @(negedge clk); addr = 0; wdata = 16'h0100; we = 1; cint = 1;
    @(negedge clk); we = 0; cint = 0;
    rd(0, d); chk("R5 set wins", d, 16'h0100);
    wr(0, 16'h0100);
  endtask

  task automatic t_parity();
    logic [15:0] d;
    strobe(20'hA5C3E, 1'b1, 1'b0);
    rd(0, d); chk("R6 flag", d, 16'h0200);
    chk("R9 irq pien off", {15'b0, irq}, 16'h0);
    rd(1, d); chk("R6 ctl capture", d, 16'h008A);
    rd(2, d); chk("R6 low capture", d, 16'h5C3E);
    strobe(20'h12345, 1'b0, 1'b1);
    rd(1, d); chk("R7 ctl frozen", d, 16'h008A);
    rd(2, d); chk("R7 low frozen", d, 16'h5C3E);
    wr(0, 16'h0800);
    chk("R9 irq via pien", {15'b0, irq}, 16'h1);
    wr(2, 16'hFFFF); wr(3, 16'hFFFF);
    rd(2, d); chk("R10 low not writable", d, 16'h5C3E);
    rd(3, d); chk("R10 addr3 zero", d, 16'h0);
    wr(1, 16'h0100);
    rd(0, d); chk("R8 ack clears", d, 16'h0800);
    chk("R9 irq after ack", {15'b0, irq}, 16'h0);
    rd(1, d); chk("R8 ack reads 0 keeps data", d, 16'h008A);
    strobe(20'h12345, 1'b0, 1'b1);
    rd(1, d); chk("R8 rearmed ctl", d, 16'h0041);
    rd(2, d); chk("R8 rearmed low", d, 16'h2345);
    wr(1, 16'h0100); wr(0, 16'h0000);
  endtask

  task automatic t_reset_bit();
    logic [15:0] d;
    wr(0, 16'h9800);
    chk("R2 reset out", {15'b0, rst_o}, 16'h1);
    pulse_int();
    strobe(20'h0BEEF, 1'b1, 1'b1);
    rd(0, d); chk("R2 flags held", d, 16'h9800);
    rd(2, d); chk("R2 strobe ignored", d, 16'h2345);
    chk("R9 no irq in reset", {15'b0, irq}, 16'h0);
    wr(0, 16'h0000);
    chk("R2 reset released", {15'b0, rst_o}, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_status_rw();
    t_attention();
    t_int_flag();
    t_parity();
    t_reset_bit();
    finish_run();
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule